// File: doc/BRIEF.md
# Dual-Mode Sliding Window Extractor

This block takes a raster stream of high-resolution pixels, at most one per cycle, and presents a square neighbourhood of recent pixels to downstream arithmetic. It has two window sizes. In interpolation mode it presents a 2×2 neighbourhood, which a bilinear interpolator uses to build an initial estimate. In convolution mode it presents an S×S neighbourhood, which a point-spread-function convolver uses. The same storage serves both modes: S−1 line delays chained through an S×S register array.

The block is also the timing master of the datapath around it. For every accepted pixel it raises a window strobe when a complete window that does not cross a line edge is present. It raises an exit strobe, together with the oldest pixel of the active window, once that pixel is no longer needed by the window and can pass to the next processing stage. It also flags the first valid window of each line and of each frame, and reports the raster position of the newest pixel so that downstream logic can treat image borders.

The mode request is sampled only on the first pixel of each frame. When the sampled mode differs from the mode in use, all stored pixels from the previous frame are cleared, so that no window in the new frame carries data from the old one.

Top module: `sliding_window_extractor`

## Requirements
- R1: Output `win_data` holds window entry (r,c) at bits [(r*S+c)*DW +: DW], where r counts lines back and c counts pixels back from the newest accepted pixel (r=0, c=0 is the newest). Entry (r,c) equals the pixel accepted r*LINE_W+c pixels before the newest one, counted across frame ends when no flush took place. Entries with r or c of 2 or more read zero in interpolation mode.
- R2: In interpolation mode (`mode_sel`=0), `win_valid` is high for an accepted pixel exactly when its row is at least 1 and its column is at least 1. The first valid window of a frame therefore follows the (LINE_W+2)-th pixel.
- R3: In convolution mode (`mode_sel`=1), `win_valid` is high for an accepted pixel exactly when its row and its column are both at least S−1. The first valid window therefore follows pixel number LINE_W*(S−1)+S.
- R4: All strobes are high only in the cycle after an accepted pixel (`in_valid`=1) and are low after a cycle with no accepted pixel. The stored pixels move only on accepted pixels.
- R5: With E=2 in interpolation mode and E=S in convolution mode, `exit_valid` is high for every accepted pixel whose index within the frame is at least (E−1)*LINE_W+E−1, including at line edges. `exit_pixel` is then the pixel (E−1)*LINE_W+E−1 positions earlier in the frame.
- R6: `line_start` marks a valid window whose newest column is E−1. `frame_start` additionally requires that the newest row is E−1.
- R7: `win_col` and `win_row` give the column and row of the newest accepted pixel within its frame, and are held between accepted pixels.
- R8: `mode_sel` is sampled only with the first pixel of a frame (row 0, column 0). A change at any other time has no effect on `win_mode`, the window size or the strobes. `win_mode` shows the mode of the newest pixel's frame.
- R9: When the sampled mode differs from the mode in use, every stored pixel except the newest is cleared to zero, so window entries that point before the frame start read zero.
- R10: After reset all strobes are low, `win_mode` is 0 (interpolation) and `win_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_pixel | input | DW | Incoming pixel, raster order |
| mode_sel | input | 1 | Requested mode: 0 = 2×2 interpolation, 1 = S×S convolution |
| win_valid | output | 1 | Complete, non-straddling window present |
| win_data | output | S*S*DW | Window entries, layout as in R1 |
| win_mode | output | 1 | Mode in use for the newest pixel |
| win_col | output | $clog2(LINE_W) | Column of the newest pixel |
| win_row | output | $clog2(FRAME_H) | Row of the newest pixel |
| exit_valid | output | 1 | Oldest window pixel leaves this cycle |
| exit_pixel | output | DW | Pixel that leaves the window |
| line_start | output | 1 | First valid window of a line |
| frame_start | output | 1 | First valid window of a frame |

## Verification
A small configuration (8-pixel lines, 6 lines, S=4) is streamed over four frames whose modes alternate. This covers a first frame, a switch into convolution mode with a flush, a repeated mode with no flush and a switch back. Every window entry, position, strobe and exit pixel is compared with a value computed from the pixel index. A frame with periodic idle cycles separates advancing on accepted pixels from advancing on every clock. Mode requests toggled mid-frame check that only the first pixel of a frame samples the mode. Entries that point before the frame start separate the flushed case (zero) from the continued case (the previous frame's pixels).

// File: rtl/swe_pkg.sv
package swe_pkg;
  typedef enum logic {
    MODE_INTERP = 1'b0,
    MODE_CONV   = 1'b1
  } swe_mode_e;
endpackage

// File: rtl/swe_line_fifo.sv
// Fixed-delay line store: one entry moves per enabled cycle.
module swe_line_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flush,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
    end else if (en) begin
      mem_d[0] = din;
      for (int i = 1; i < DEPTH; i++) mem_d[i] = mem_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (en || flush) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign dout = mem_q[DEPTH-1];
endmodule

// File: rtl/swe_window_array.sv
// S x S tap registers; rows 1..S-1 fed through line delays.
module swe_window_array #(
  parameter int DW     = 8,
  parameter int S      = 4,
  parameter int LINE_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            flush,
  input  logic [DW-1:0]   din,
  output logic [S*S*DW-1:0] taps
);
  localparam int FIFO_DEPTH = LINE_W - S;

  logic [DW-1:0] w_q [S][S];
  logic [DW-1:0] w_d [S][S];
  logic [DW-1:0] line_out [S-1];

  genvar gr;
  generate
    for (gr = 1; gr < S; gr++) begin : g_line
      swe_line_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .flush(flush),
        .din  (w_q[gr-1][S-1]),
        .dout (line_out[gr-1])
      );
    end
  endgenerate

  always_comb begin
    // newest position always takes the incoming pixel
    w_d[0][0] = din;
    for (int c = 1; c < S; c++) w_d[0][c] = flush ? '0 : w_q[0][c-1];
    for (int r = 1; r < S; r++) begin
      w_d[r][0] = flush ? '0 : line_out[r-1];
      for (int c = 1; c < S; c++) w_d[r][c] = flush ? '0 : w_q[r][c-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < S; r++)
        for (int c = 0; c < S; c++) w_q[r][c] <= '0;
    end else if (en) begin
      for (int r = 0; r < S; r++)
        for (int c = 0; c < S; c++) w_q[r][c] <= w_d[r][c];
    end
  end

  always_comb begin
    for (int r = 0; r < S; r++)
      for (int c = 0; c < S; c++) taps[(r*S+c)*DW +: DW] = w_q[r][c];
  end
endmodule

// File: rtl/swe_pos_tracker.sv
// Raster position, mode sampling and synchronisation strobes.
module swe_pos_tracker
  import swe_pkg::*;
#(
  parameter int S       = 4,
  parameter int LINE_W  = 64,
  parameter int FRAME_H = 48,
  parameter int CW      = $clog2(LINE_W),
  parameter int RW      = $clog2(FRAME_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          mode_sel,
  output logic          flush,
  output swe_mode_e     mode,
  output logic          win_valid,
  output logic          exit_valid,
  output logic          line_start,
  output logic          frame_start,
  output logic [CW-1:0] win_col,
  output logic [RW-1:0] win_row
);
  localparam logic [CW-1:0] COL_LAST = CW'(LINE_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(FRAME_H - 1);
  localparam logic [CW-1:0] COL_CONV = CW'(S - 1);
  localparam logic [RW-1:0] ROW_CONV = RW'(S - 1);

  logic [CW-1:0] col_q, col_d, wcol_q, wcol_d;
  logic [RW-1:0] row_q, row_d, wrow_q, wrow_d;
  swe_mode_e     mode_q, mode_d;
  logic          wv_q, wv_d, ev_q, ev_d, ls_q, ls_d, fs_q, fs_d;
  logic          first_pix;
  logic [CW-1:0] e_col;
  logic [RW-1:0] e_row;

  always_comb begin
    first_pix = (col_q == '0) && (row_q == '0);
    mode_d    = mode_q;
    if (in_valid && first_pix) mode_d = swe_mode_e'(mode_sel);
    flush = in_valid && first_pix && (mode_sel != logic'(mode_q));

    e_col = (mode_d == MODE_CONV) ? COL_CONV : CW'(1);
    e_row = (mode_d == MODE_CONV) ? ROW_CONV : RW'(1);

    wv_d = in_valid && (row_q >= e_row) && (col_q >= e_col);
    ev_d = in_valid && ((row_q > e_row) || ((row_q == e_row) && (col_q >= e_col)));
    ls_d = wv_d && (col_q == e_col);
    fs_d = ls_d && (row_q == e_row);

    col_d  = col_q;
    row_d  = row_q;
    wcol_d = wcol_q;
    wrow_d = wrow_q;
    if (in_valid) begin
      wcol_d = col_q;
      wrow_d = row_q;
      if (col_q == COL_LAST) begin
        col_d = '0;
        row_d = (row_q == ROW_LAST) ? '0 : row_q + RW'(1);
      end else begin
        col_d = col_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      wcol_q <= '0;
      wrow_q <= '0;
      mode_q <= MODE_INTERP;
      wv_q   <= 1'b0;
      ev_q   <= 1'b0;
      ls_q   <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      col_q  <= col_d;
      row_q  <= row_d;
      wcol_q <= wcol_d;
      wrow_q <= wrow_d;
      mode_q <= mode_d;
      wv_q   <= wv_d;
      ev_q   <= ev_d;
      ls_q   <= ls_d;
      fs_q   <= fs_d;
    end
  end

  assign mode        = mode_q;
  assign win_valid   = wv_q;
  assign exit_valid  = ev_q;
  assign line_start  = ls_q;
  assign frame_start = fs_q;
  assign win_col     = wcol_q;
  assign win_row     = wrow_q;
endmodule

// File: rtl/sliding_window_extractor.sv
module sliding_window_extractor
  import swe_pkg::*;
#(
  parameter int DW      = 8,
  parameter int S       = 4,
  parameter int LINE_W  = 64,
  parameter int FRAME_H = 48,
  parameter int CW      = $clog2(LINE_W),
  parameter int RW      = $clog2(FRAME_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_pixel,
  input  logic              mode_sel,
  output logic              win_valid,
  output logic [S*S*DW-1:0] win_data,
  output logic              win_mode,
  output logic [CW-1:0]     win_col,
  output logic [RW-1:0]     win_row,
  output logic              exit_valid,
  output logic [DW-1:0]     exit_pixel,
  output logic              line_start,
  output logic              frame_start
);
  localparam int SMALL    = 2;
  localparam int OLD_CONV = ((S-1)*S + (S-1)) * DW;
  localparam int OLD_INTP = (S + 1) * DW;

  logic              flush;
  swe_mode_e         mode;
  logic [S*S*DW-1:0] taps;

  swe_pos_tracker #(.S(S), .LINE_W(LINE_W), .FRAME_H(FRAME_H), .CW(CW), .RW(RW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode_sel   (mode_sel),
    .flush      (flush),
    .mode       (mode),
    .win_valid  (win_valid),
    .exit_valid (exit_valid),
    .line_start (line_start),
    .frame_start(frame_start),
    .win_col    (win_col),
    .win_row    (win_row)
  );

  swe_window_array #(.DW(DW), .S(S), .LINE_W(LINE_W)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_valid),
    .flush(flush),
    .din  (in_pixel),
    .taps (taps)
  );

  // Entries outside the 2x2 corner are blanked in interpolation mode.
  genvar gr, gc;
  generate
    for (gr = 0; gr < S; gr++) begin : g_row
      for (gc = 0; gc < S; gc++) begin : g_col
        if (gr < SMALL && gc < SMALL) begin : g_keep
          assign win_data[(gr*S+gc)*DW +: DW] = taps[(gr*S+gc)*DW +: DW];
        end else begin : g_mask
          assign win_data[(gr*S+gc)*DW +: DW] =
            (mode == MODE_CONV) ? taps[(gr*S+gc)*DW +: DW] : '0;
        end
      end
    end
  endgenerate

  assign exit_pixel = (mode == MODE_CONV) ? taps[OLD_CONV +: DW] : taps[OLD_INTP +: DW];
  assign win_mode   = logic'(mode);
endmodule

// File: rtl/swe_checker.sv
module swe_checker #(
  parameter int DW      = 8,
  parameter int S       = 4,
  parameter int CW      = 6,
  parameter int RW      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              win_valid,
  input logic [S*S*DW-1:0] win_data,
  input logic              win_mode,
  input logic [CW-1:0]     win_col,
  input logic [RW-1:0]     win_row,
  input logic              exit_valid,
  input logic              line_start,
  input logic              frame_start
);
  // R4
  strobe_needs_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!win_valid && !exit_valid && !line_start && !frame_start));

  // R2 R3
  no_straddle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_col >= (win_mode ? CW'(S-1) : CW'(1))));

  // R5
  exit_with_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> exit_valid);

  // R6
  line_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> win_valid);

  // R6
  frame_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_start && (win_row == (win_mode ? RW'(S-1) : RW'(1)))));

  // R8
  mode_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(win_mode) |-> (win_col == '0 && win_row == '0));

  // R1
  newest_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid) && win_col != '0) |-> (win_data[DW +: DW] == $past(win_data[0 +: DW])));

  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(win_col) && $stable(win_row)));
endmodule

bind sliding_window_extractor swe_checker #(.DW(DW), .S(S), .CW(CW), .RW(RW)) u_swe_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .win_valid  (win_valid),
  .win_data   (win_data),
  .win_mode   (win_mode),
  .win_col    (win_col),
  .win_row    (win_row),
  .exit_valid (exit_valid),
  .line_start (line_start),
  .frame_start(frame_start)
);

// File: tb/sliding_window_extractor_bench.sv
module sliding_window_extractor_bench;
  localparam int DW = 8;
  localparam int S  = 4;
  localparam int W  = 8;
  localparam int H  = 6;
  localparam int NP = W * H;
  localparam int NF = 4;
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [DW-1:0]     in_pixel;
  logic              mode_sel;
  logic              win_valid;
  logic [S*S*DW-1:0] win_data;
  logic              win_mode;
  logic [CW-1:0]     win_col;
  logic [RW-1:0]     win_row;
  logic              exit_valid;
  logic [DW-1:0]     exit_pixel;
  logic              line_start;
  logic              frame_start;

  sliding_window_extractor #(.DW(DW), .S(S), .LINE_W(W), .FRAME_H(H)) u_sliding_window_extractor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel), .mode_sel(mode_sel),
    .win_valid(win_valid), .win_data(win_data), .win_mode(win_mode), .win_col(win_col),
    .win_row(win_row), .exit_valid(exit_valid), .exit_pixel(exit_pixel),
    .line_start(line_start), .frame_start(frame_start)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int  ntest = 0;
  int  nfail = 0;
  bit  done  = 1'b0;
  bit  prev_acc = 1'b0;
  int  prev_f = 0;
  int  prev_k = 0;
  bit  fmode [NF];
  bit  flushed [NF];

  function automatic int pix(int f, int k);
    return ((f * 59 + k * 7 + 3) % 255) + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    chk(win_valid == 1'b0, req, "win_valid idle", int'(win_valid), 0);
    chk(exit_valid == 1'b0, req, "exit_valid idle", int'(exit_valid), 0);
    chk(line_start == 1'b0, req, "line_start idle", int'(line_start), 0);
    chk(frame_start == 1'b0, req, "frame_start idle", int'(frame_start), 0);
  endtask

  task automatic check_accept(int f, int k);
    int  e, row, col, fill, idx, exp, act;
    bit  exp_wv, exp_ev;
    string rq;
    e      = fmode[f] ? S : 2;
    rq     = fmode[f] ? "R3" : "R2";
    row    = k / W;
    col    = k % W;
    exp_wv = (row >= e - 1) && (col >= e - 1);
    fill   = (e - 1) * W + e - 1;
    exp_ev = (k >= fill);
    chk(win_valid == exp_wv, rq, "win_valid", int'(win_valid), int'(exp_wv));
    chk(int'(win_col) == col, "R7", "win_col", int'(win_col), col);
    chk(int'(win_row) == row, "R7", "win_row", int'(win_row), row);
    chk(win_mode == fmode[f], "R8", "win_mode", int'(win_mode), int'(fmode[f]));
    chk(exit_valid == exp_ev, "R5", "exit_valid", int'(exit_valid), int'(exp_ev));
    if (exp_ev)
      chk(int'(exit_pixel) == pix(f, k - fill), "R5", "exit_pixel", int'(exit_pixel), pix(f, k - fill));
    chk(line_start == (exp_wv && col == e - 1), "R6", "line_start", int'(line_start),
        int'(exp_wv && col == e - 1));
    chk(frame_start == (row == e - 1 && col == e - 1), "R6", "frame_start", int'(frame_start),
        int'(row == e - 1 && col == e - 1));
    for (int r = 0; r < S; r++) begin
      for (int c = 0; c < S; c++) begin
        act = int'(win_data[(r*S+c)*DW +: DW]);
        idx = k - r * W - c;
        if (r >= e || c >= e) begin
          chk(act == 0, "R1", "masked entry", act, 0);
        end else if (idx >= 0) begin
          chk(act == pix(f, idx), "R1", "window entry", act, pix(f, idx));
        end else if (flushed[f]) begin
          chk(act == 0, "R9", "flushed entry", act, 0);
        end else if (f > 0) begin
          exp = pix(f - 1, NP + idx);
          chk(act == exp, "R1", "entry from previous frame", act, exp);
        end
      end
    end
  endtask

  task automatic step(bit v, int f, int k, bit m);
    @(negedge clk);
    if (prev_acc) check_accept(prev_f, prev_k);
    else check_idle("R4");
    in_valid = v;
    in_pixel = v ? DW'(pix(f, k)) : DW'(8'hA5);
    mode_sel = m;
    prev_acc = v;
    prev_f   = f;
    prev_k   = k;
  endtask

  initial begin
    fmode[0] = 1'b0; fmode[1] = 1'b1; fmode[2] = 1'b1; fmode[3] = 1'b0;
    flushed[0] = 1'b0;
    for (int f = 1; f < NF; f++) flushed[f] = (fmode[f] != fmode[f-1]);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_pixel = '0;
    mode_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check_idle("R10");
    chk(win_mode == 1'b0, "R10", "win_mode after reset", int'(win_mode), 0);
    chk(win_data == '0, "R10", "win_data after reset", 0, 0);
    for (int f = 0; f < NF; f++) begin
      for (int k = 0; k < NP; k++) begin
        bit m;
        m = fmode[f];
        // R8: requests away from the first pixel must be ignored
        if (f == 1 && k >= 10 && k <= 20) m = 1'b0;
        if (f == 3 && k >= 5 && k <= 9) m = 1'b1;
        // R4: idle cycles inside frame 2
        if (f == 2 && (k % 5) == 3) step(1'b0, f, k, m);
        step(1'b1, f, k, m);
      end
    end
    step(1'b0, 0, 0, 1'b0);
    step(1'b0, 0, 0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      ntest++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule